// File: doc/BRIEF.md
# Multi-Stream Wake Pattern Matcher

This block watches the first words of a received frame and compares them against nine wake-up patterns at the same time. The patterns live in a small table of 64-bit rows. Each row holds a 16-bit control field and three 16-bit pattern slots, and each slot belongs to a different stream. Frame word `w` selects the group of rows `3w` to `3w+2`. The incoming word is compared against all nine slots of that group in the same cycle.

The control field decides, for each slot, which bytes take part in the comparison and whether this word is the last one of that stream. Streams can therefore end after one, two or three words. Each stream keeps a running match flag from start of frame. When the last compared word of the frame has been processed and at least one stream has matched, the block raises a one-cycle wake pulse. A nine-bit vector names the streams that matched. Rows are loaded through a plain write port while no frame is being compared.

Top module: `wake_match_top`

## Requirements
- R1: Row `3w+g` holds the patterns for frame word `w`. Slot 0 is bits [47:32], slot 1 is bits [31:16] and slot 2 is bits [15:0]. Slot `k` of row group offset `g` belongs to stream `3g+k`, which is bit `3g+k` of `wake_mask`.
- R2: The byte enables are: slot 0 high/low at bits 61/60, slot 1 high/low at bits 59/58, slot 2 high/low at bits 57/56. The high byte is word bits [15:8]. A byte whose enable is clear never causes a mismatch, whatever its value.
- R3: The done flags are bits 50, 49 and 48, for slots 0, 1 and 2. A set flag marks the last word of that stream. Words after it have no effect on that stream.
- R4: A stream matches only if every enabled byte matched in every word up to and including its done word. One mismatch removes the stream for the rest of the frame.
- R5: A stream whose words carry no done flag never matches, even when all of its enabled bytes agree.
- R6: Control bits [63:62] and [55:51] are reserved. Their value has no effect on any result.
- R7: A row write is ignored from the cycle `sof` is high until the cycle that compares the last frame word, inclusive.
- R8: One cycle after the clock edge that compares frame word 2, `wake` is high for exactly one cycle, and only if at least one stream matched.
- R9: Bit `s` of `wake_mask` is set from the cycle after the word that completes stream `s` with a match. It only gains bits during a frame and clears the cycle after `sof`.
- R10: After reset, `wake` and `wake_mask` are zero, every row is zero and no stream can match.
- R11: `word_valid` is ignored in the `sof` cycle, outside a frame, and after frame word 2 until the next `sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start of frame, one cycle |
| word_valid | input | 1 | A frame word is on `word_data` |
| word_data | input | 16 | Frame word |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 4 | Row index, 0 to 8 |
| wr_data | input | 64 | Row contents |
| wake | output | 1 | One-cycle wake pulse |
| wake_mask | output | 9 | Streams that matched in this frame |

## Verification
Every result is one register stage from its cause. The wake-mask bits for a word appear one cycle after the edge that compares that word. `wake` rises one cycle after the edge that compares word 2, and the mask clears one cycle after `sof`. The bench drives inputs on falling edges and reads the outputs at the next falling edge, half a cycle after the edge that updates them. It checks the partial mask after word 0, and the full mask and the wake pulse after word 2. On the following falling edge it checks that the pulse has dropped. Expected masks come from a bench model that walks the written rows word by word.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int SLOT_W = 16;
    localparam int SLOTS  = 3;
    localparam int ROW_W  = 64;

    // Stored part of a row: reserved control bits are never kept.
    typedef struct packed {
        logic [2*SLOTS-1:0]           byte_en;
        logic [SLOTS-1:0]             done;
        logic [SLOTS-1:0][SLOT_W-1:0] slot;
    } pat_core_t;

    function automatic pat_core_t to_core(input logic [ROW_W-1:0] raw);
        pat_core_t c;
        c.byte_en = raw[61:56];
        c.done    = raw[50:48];
        c.slot    = raw[47:0];
        return c;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_pat(input pat_core_t r, input int k);
        return r.slot[SLOTS-1-k];
    endfunction

    function automatic logic slot_en_hi(input pat_core_t r, input int k);
        return r.byte_en[2*(SLOTS-1-k)+1];
    endfunction

    function automatic logic slot_en_lo(input pat_core_t r, input int k);
        return r.byte_en[2*(SLOTS-1-k)];
    endfunction

    function automatic logic slot_done(input pat_core_t r, input int k);
        return r.done[SLOTS-1-k];
    endfunction

    function automatic logic bytes_agree(input logic [SLOT_W-1:0] word,
                                         input logic [SLOT_W-1:0] pat,
                                         input logic en_hi, input logic en_lo);
        return (!en_hi || word[15:8] == pat[15:8]) &&
               (!en_lo || word[7:0]  == pat[7:0]);
    endfunction
endpackage

// File: rtl/wake_pattern_mem.sv
module wake_pattern_mem
    import wake_pkg::*;
#(
    parameter int N_ROWS  = 9,
    parameter int GRP     = 3,
    parameter int ADDR_W  = 4,
    parameter int IDX_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_block,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  pat_core_t             wr_row,
    input  logic [IDX_W-1:0]      rd_idx,
    output pat_core_t             rd_rows [GRP]
);
    pat_core_t rows_q [N_ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N_ROWS; r++) rows_q[r] <= '0;
        end else if (wr_en && !wr_block) begin
            for (int r = 0; r < N_ROWS; r++)
                if (wr_addr == ADDR_W'(r)) rows_q[r] <= wr_row;
        end
    end

    always_comb begin
        for (int g = 0; g < GRP; g++) begin
            rd_rows[g] = '0;
            for (int r = 0; r < N_ROWS; r++)
                if (r == int'(rd_idx) * GRP + g) rd_rows[g] = rows_q[r];
        end
    end
endmodule

// File: rtl/wake_frame_seq.sv
module wake_frame_seq #(
    parameter int DEPTH = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic             word_valid,
    output logic             active,
    output logic             cmp,
    output logic             last,
    output logic [IDX_W-1:0] word_idx
);
    assign cmp  = active && word_valid && !sof;
    assign last = (word_idx == IDX_W'(DEPTH-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            word_idx <= '0;
        end else if (sof) begin
            active   <= 1'b1;
            word_idx <= '0;
        end else if (cmp) begin
            if (last) active <= 1'b0;
            else      word_idx <= word_idx + 1'b1;
        end
    end
endmodule

// File: rtl/wake_stream_trk.sv
module wake_stream_trk
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic              cmp,
    input  logic [SLOT_W-1:0] word,
    input  logic [SLOT_W-1:0] pat,
    input  logic              en_hi,
    input  logic              en_lo,
    input  logic              fin_here,
    output logic              hit
);
    logic alive_q, closed_q, agree;

    assign agree = bytes_agree(word, pat, en_hi, en_lo);
    assign hit   = cmp && !closed_q && alive_q && agree && fin_here;

    always_ff @(posedge clk) begin
        if (rst) begin
            alive_q  <= 1'b0;
            closed_q <= 1'b1;
        end else if (sof) begin
            alive_q  <= 1'b1;
            closed_q <= 1'b0;
        end else if (cmp && !closed_q) begin
            if (!agree)   alive_q  <= 1'b0;
            if (fin_here) closed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wake_match_top.sv
module wake_match_top
    import wake_pkg::*;
#(
    parameter  int DEPTH   = 3,
    parameter  int GRP     = 3,
    localparam int STREAMS = GRP * SLOTS,
    localparam int N_ROWS  = DEPTH * GRP,
    localparam int ADDR_W  = $clog2(N_ROWS),
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sof,
    input  logic               word_valid,
    input  logic [SLOT_W-1:0]  word_data,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ROW_W-1:0]   wr_data,
    output logic               wake,
    output logic [STREAMS-1:0] wake_mask
);
    logic             frame_active, cmp, last;
    logic [IDX_W-1:0] word_idx;
    pat_core_t        rd_rows [GRP];
    logic [STREAMS-1:0] hits, mask_q;
    logic             wake_q;
    logic             unused_rsv;

    assign unused_rsv = ^{wr_data[63:62], wr_data[55:51]};

    wake_frame_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .sof(sof), .word_valid(word_valid),
        .active(frame_active), .cmp(cmp), .last(last), .word_idx(word_idx)
    );

    wake_pattern_mem #(.N_ROWS(N_ROWS), .GRP(GRP), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_block(frame_active || sof),
        .wr_addr(wr_addr), .wr_row(to_core(wr_data)),
        .rd_idx(word_idx), .rd_rows(rd_rows)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_stream
        localparam int G = s / SLOTS;
        localparam int K = s % SLOTS;
        wake_stream_trk u_trk (
            .clk(clk), .rst(rst), .sof(sof), .cmp(cmp), .word(word_data),
            .pat(slot_pat(rd_rows[G], K)),
            .en_hi(slot_en_hi(rd_rows[G], K)),
            .en_lo(slot_en_lo(rd_rows[G], K)),
            .fin_here(slot_done(rd_rows[G], K)),
            .hit(hits[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= cmp && last && |(mask_q | hits);
            if (sof)      mask_q <= '0;
            else if (cmp) mask_q <= mask_q | hits;
        end
    end

    assign wake      = wake_q;
    assign wake_mask = mask_q;
endmodule

// File: rtl/wake_match_chk.sv
module wake_match_chk #(
    parameter int N_STREAMS = 9
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sof,
    input logic                 frame_active,
    input logic                 wake,
    input logic [N_STREAMS-1:0] wake_mask
);
    // R8
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    // R8
    wake_mask_nz_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> (wake_mask != '0));

    // R9
    sof_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sof |=> (wake_mask == '0));

    // R9
    mask_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !sof |=> ((wake_mask & $past(wake_mask)) == $past(wake_mask)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_active && !sof) |=> (wake_mask == $past(wake_mask)));

    // R11
    idle_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_active |=> !wake);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!wake && wake_mask == '0));
endmodule

bind wake_match_top wake_match_chk #(.N_STREAMS(STREAMS)) u_chk (
    .clk(clk), .rst(rst), .sof(sof), .frame_active(frame_active),
    .wake(wake), .wake_mask(wake_mask)
);

// File: tb/wake_match_top_bench.sv
`timescale 1ns/1ps
module wake_match_top_bench;
    logic        clk = 1'b0;
    logic        rst, sof, word_valid, wr_en;
    logic [15:0] word_data;
    logic [3:0]  wr_addr;
    logic [63:0] wr_data;
    logic        wake;
    logic [8:0]  wake_mask;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    logic [63:0] mem_m [9];

    always #4 clk = ~clk;

    wake_match_top u_wake_match_top (
        .clk(clk), .rst(rst), .sof(sof), .word_valid(word_valid), .word_data(word_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wake(wake), .wake_mask(wake_mask)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mkrow(input logic [15:0] c, input logic [15:0] s0,
                                          input logic [15:0] s1, input logic [15:0] s2);
        return {c, s0, s1, s2};
    endfunction

    // Model of R1-R5: walk n words for each stream.
    function automatic logic [8:0] model_mask(input logic [15:0] w0, input logic [15:0] w1,
                                              input logic [15:0] w2, input int n);
        logic [15:0] w [3];
        logic [8:0] m = '0;
        w[0] = w0; w[1] = w1; w[2] = w2;
        for (int s = 0; s < 9; s++) begin
            bit alive = 1, closed = 0;
            for (int k = 0; k < n; k++) begin
                logic [63:0] row = mem_m[3*k + s/3];
                int sl = s % 3;
                logic [15:0] p = row[47-16*sl -: 16];
                bit hi = row[61-2*sl], lo = row[60-2*sl], dn = row[50-sl];
                bit ok = (!hi || p[15:8] == w[k][15:8]) && (!lo || p[7:0] == w[k][7:0]);
                if (!closed) begin
                    if (!ok) alive = 0;
                    if (dn) begin
                        closed = 1;
                        if (alive) m[s] = 1'b1;
                    end
                end
            end
        end
        return m;
    endfunction

    task automatic wr_row(input int a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mem_m[a] = d;
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 9; a++) wr_row(a, 64'h0);
    endtask

    task automatic run_frame(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                             input string req, input bit mid_wr, input bit sof_junk);
        logic [8:0] e0, ef;
        e0 = model_mask(w0, w1, w2, 1);
        ef = model_mask(w0, w1, w2, 3);
        @(negedge clk);
        sof = 1'b1;
        if (sof_junk) begin word_valid = 1'b1; word_data = ~w0; end
        @(negedge clk);
        sof = 1'b0; word_valid = 1'b1; word_data = w0;
        @(negedge clk);
        check({req, " R9 mask after word0"}, wake_mask, e0);
        word_data = w1;
        if (mid_wr) begin wr_en = 1'b1; wr_addr = 4'd1; wr_data = 64'h0; end
        @(negedge clk);
        wr_en = 1'b0; word_data = w2;
        @(negedge clk);
        word_valid = 1'b0;
        check({req, " mask"}, wake_mask, ef);
        check({req, " R8 wake"}, wake, ef != 0);
        @(negedge clk);
        check({req, " R8 wake drop"}, wake, 1'b0);
    endtask

    initial begin
        rst = 1'b1; sof = 0; word_valid = 0; word_data = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        for (int a = 0; a < 9; a++) mem_m[a] = 64'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 wake", wake, 1'b0);
        check("R10 mask", wake_mask, 9'h0);
        run_frame(16'h0000, 16'h0000, 16'h0000, "R10 empty rows", 0, 0);
        check("R10 empty model", model_mask(0, 0, 0, 3), 9'h0);

        // R1/R2: stream 4, high byte only, done at word 0
        wr_row(1, mkrow(16'h0802, 16'h0, 16'hAB00, 16'h0));
        run_frame(16'hAB77, 16'h1111, 16'h2222, "R1 R2 stream4", 0, 0);
        check("R1 stream4 bit", wake_mask, 9'h010);
        run_frame(16'hAC77, 16'h1111, 16'h2222, "R2 hi mismatch", 0, 0);
        check("R2 no match", wake_mask, 9'h000);

        // R6: reserved bits set, same result
        wr_row(1, mkrow(16'hC8FA, 16'h0, 16'hAB00, 16'h0));
        run_frame(16'hAB00, 16'h1111, 16'h2222, "R6 reserved", 0, 0);
        check("R6 still matches", wake_mask, 9'h010);

        // R7: write during frame ignored
        run_frame(16'hAB00, 16'h0, 16'h0, "R7 during", 1, 0);
        run_frame(16'hAB00, 16'h0, 16'h0, "R7 after", 0, 0);
        check("R7 row kept", wake_mask, 9'h010);

        // R11: words outside a frame and in the sof cycle
        @(negedge clk);
        word_valid = 1'b1; word_data = 16'h5A5A;
        repeat (3) @(negedge clk);
        word_valid = 1'b0;
        check("R11 idle mask", wake_mask, 9'h010);
        check("R11 idle wake", wake, 1'b0);
        run_frame(16'hAB00, 16'h0, 16'h0, "R11 sof junk", 0, 1);
        check("R11 sof word ignored", wake_mask, 9'h010);

        // R3/R4: stream 8 ends at word 1
        clear_mem();
        wr_row(2, mkrow(16'h0100, 16'h0, 16'h0, 16'h0055));
        wr_row(5, mkrow(16'h0101, 16'h0, 16'h0, 16'h0066));
        wr_row(8, mkrow(16'h0100, 16'h0, 16'h0, 16'h0000));
        run_frame(16'h1255, 16'h3466, 16'hFFFF, "R3 stream8", 0, 0);
        check("R3 stream8 bit", wake_mask, 9'h100);
        run_frame(16'h1254, 16'h3466, 16'h0000, "R4 early miss", 0, 0);
        check("R4 no match", wake_mask, 9'h000);

        // R5: no done flag
        clear_mem();
        wr_row(0, mkrow(16'h3000, 16'hBEEF, 16'h0, 16'h0));
        run_frame(16'hBEEF, 16'h0, 16'h0, "R5 no done", 0, 0);
        check("R5 no match", wake_mask, 9'h000);

        // Random rows, frames aimed at one stream
        void'($urandom(32'd2024));
        for (int it = 0; it < 150; it++) begin
            int s;
            logic [15:0] w [3];
            for (int a = 0; a < 9; a++)
                wr_row(a, {$urandom(), $urandom()});
            s = $urandom % 9;
            for (int k = 0; k < 3; k++) begin
                logic [63:0] row = mem_m[3*k + s/3];
                w[k] = row[47-16*(s%3) -: 16];
                if ($urandom % 4 == 0) w[k] = w[k] ^ 16'(1 << ($urandom % 16));
            end
            run_frame(w[0], w[1], w[2], "R1 R4 random", 0, 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule